// File: doc/BRIEF.md
# Dual-Die Status and Ready Router

This block sits in front of a stack of two flash dies that share one command bus and one chip enable. Each decoded command arrives together with its assembled row address. The router works out which die owns that row from the top row bit and forwards a one-cycle launch pulse to that die only. The two dies can therefore work on separate operations at the same time, for example one erasing while the other reads. A die that is still busy does not receive a new launch, but the other die keeps accepting commands.

The router also picks the status byte that the host reads back. Two die-specific status opcodes each name one die. A plain status opcode returns the status of the die that was targeted by the most recent operation command. The chosen source stays selected, and the output keeps following that die's live status byte, until the next command arrives. The per-die busy flags are merged into one active-low ready/busy output, which copies the behaviour of a shared open-drain line.

The dies themselves are outside this block. They appear only as busy flags and status bytes.

Top module: `dual_die_router`

## Requirements
- R1: While reset is held, and on the first sampled cycle after reset is released, `die_launch` is 00b, `rdy_n_busy` is 1 and `host_status` is 00h.
- R2: A non-status command whose row address has bit 18 at 0 raises `die_launch` to 01b for exactly one cycle, starting one clock after the command, provided die 0 is not busy.
- R3: A non-status command whose row address has bit 18 at 1 raises `die_launch` to 10b for exactly one cycle, starting one clock after the command, provided die 1 is not busy.
- R4: A command aimed at a busy die produces no launch for that die. A command aimed at the other, idle die is still launched in the same situation.
- R5: After opcode F2h, `host_status` equals die 0's status byte, starting one clock after the command.
- R6: After opcode F3h, `host_status` equals die 1's status byte, starting one clock after the command.
- R7: After opcode 70h, `host_status` shows the status of the die targeted by the last non-status command. That die is recorded even when its launch was blocked. After reset, and before any such command, it is die 0.
- R8: The selected status source is kept while no new command arrives, and `host_status` follows that die's live byte. A non-status command clears the selection, so `host_status` reads 00h.
- R9: `rdy_n_busy` is 0 one clock after either `die_busy` bit is 1, and 1 one clock after both are 0.
- R10: Status opcodes (70h, F2h, F3h) never raise `die_launch` and do not change the recorded last-targeted die.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_op | input | 8 | Opcode of the command |
| cmd_row | input | 19 | Assembled row address of the command; bit 18 selects the die |
| die_busy | input | 2 | Busy flag per die, bit i for die i |
| die0_stat | input | 8 | Status byte of die 0 |
| die1_stat | input | 8 | Status byte of die 1 |
| die_launch | output | 2 | One-cycle launch pulse per die |
| host_status | output | 8 | Status byte chosen for the host |
| rdy_n_busy | output | 1 | Combined ready/busy, 0 while either die is busy |

## Verification
A command changes `die_launch` and the status selection at the first rising edge that sees it. `rdy_n_busy` follows the busy flags at that same edge. Once the selection is set, `host_status` follows the live status inputs with no further register in between. The bench applies every stimulus on a falling edge and lets one rising edge pass. It then compares all three outputs on the next falling edge against a bench model, before it drives the next stimulus. Idle cycles between commands check that the selection is held while the live status bytes change.

// File: rtl/dd_route_pkg.sv
package dd_route_pkg;
  localparam int NUM_DIES = 2;
  localparam logic [7:0] OP_STAT_LAST = 8'h70;
  localparam logic [7:0] OP_STAT_DIE0 = 8'hF2;
  localparam logic [7:0] OP_STAT_DIE1 = 8'hF3;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_DIE0 = 2'd1,
    SRC_DIE1 = 2'd2
  } stat_src_e;
endpackage

// File: rtl/dd_cmd_classify.sv
module dd_cmd_classify
  import dd_route_pkg::*;
#(
  parameter int ROW_W = 19
) (
  input  logic [7:0]       op,
  input  logic [ROW_W-1:0] row,
  output logic             is_stat_last,
  output logic             is_stat_d0,
  output logic             is_stat_d1,
  output logic             is_work,
  output logic             row_die
);
  localparam int DIE_BIT = ROW_W - 1;

  always_comb begin
    is_stat_last = (op == OP_STAT_LAST);
    is_stat_d0   = (op == OP_STAT_DIE0);
    is_stat_d1   = (op == OP_STAT_DIE1);
    is_work      = !(is_stat_last || is_stat_d0 || is_stat_d1);
    row_die      = row[DIE_BIT];
  end
endmodule

// File: rtl/dd_launch_ctrl.sv
module dd_launch_ctrl
  import dd_route_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic                is_work,
  input  logic                row_die,
  input  logic [NUM_DIES-1:0] die_busy,
  output logic [NUM_DIES-1:0] launch,
  output logic                last_die
);
  logic [NUM_DIES-1:0] launch_d;
  logic                last_d;
  logic                take;

  assign take = cmd_valid && is_work;

  always_comb begin
    last_d = last_die;
    if (take) last_d = row_die;
  end

  for (genvar g = 0; g < NUM_DIES; g++) begin : g_die
    assign launch_d[g] = take && (row_die == 1'(g)) && !die_busy[g];

    // busy die never launched (R4)
    assert_busy_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
      launch[g] |-> $past(!die_busy[g] && cmd_valid))
      else $error("launch to busy die %0d", g);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      launch   <= '0;
      last_die <= 1'b0;
    end else begin
      launch   <= launch_d;
      last_die <= last_d;
    end
  end

  assert_onehot_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(launch)) else $error("both dies launched");

  assert_stat_no_launch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !is_work) |=> (launch == '0 && $stable(last_die)))
    else $error("status opcode launched or moved last die");
endmodule

// File: rtl/dd_status_sel.sv
module dd_status_sel
  import dd_route_pkg::*;
#(
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              is_stat_last,
  input  logic              is_stat_d0,
  input  logic              is_stat_d1,
  input  logic              last_die,
  input  logic [STAT_W-1:0] d0_stat,
  input  logic [STAT_W-1:0] d1_stat,
  output logic [STAT_W-1:0] stat_out
);
  stat_src_e src_q, src_d;

  always_comb begin
    src_d = src_q;
    if (cmd_valid) begin
      if (is_stat_d0)        src_d = SRC_DIE0;
      else if (is_stat_d1)   src_d = SRC_DIE1;
      else if (is_stat_last) src_d = last_die ? SRC_DIE1 : SRC_DIE0;
      else                   src_d = SRC_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= SRC_NONE;
    else        src_q <= src_d;
  end

  always_comb begin
    case (src_q)
      SRC_DIE0: stat_out = d0_stat;
      SRC_DIE1: stat_out = d1_stat;
      default:  stat_out = '0;
    endcase
  end

  assert_src_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(src_q)) else $error("status source moved without command");

  assert_f2_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && is_stat_d0) |=> (stat_out == d0_stat)) else $error("F2 select wrong");
endmodule

// File: rtl/dd_ready_merge.sv
module dd_ready_merge
  import dd_route_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_DIES-1:0] die_busy,
  output logic                rdy_n
);
  logic rdy_d;

  assign rdy_d = ~(|die_busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_n <= 1'b1;
    else        rdy_n <= rdy_d;
  end

  assert_any_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|die_busy) |=> !rdy_n) else $error("ready shown while a die busy");
endmodule

// File: rtl/dual_die_router.sv
module dual_die_router
  import dd_route_pkg::*;
#(
  parameter int ROW_W  = 19,
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_op,
  input  logic [ROW_W-1:0]  cmd_row,
  input  logic [1:0]        die_busy,
  input  logic [STAT_W-1:0] die0_stat,
  input  logic [STAT_W-1:0] die1_stat,
  output logic [1:0]        die_launch,
  output logic [STAT_W-1:0] host_status,
  output logic              rdy_n_busy
);
  logic [1:0] rst_pipe;
  logic       rst_n_s;
  logic       is_last, is_d0, is_d1, is_work, row_die, last_die;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  dd_cmd_classify #(.ROW_W(ROW_W)) u_cls (
    .op(cmd_op), .row(cmd_row), .is_stat_last(is_last), .is_stat_d0(is_d0),
    .is_stat_d1(is_d1), .is_work(is_work), .row_die(row_die)
  );

  dd_launch_ctrl u_launch (
    .clk(clk), .rst_n(rst_n_s), .cmd_valid(cmd_valid), .is_work(is_work),
    .row_die(row_die), .die_busy(die_busy), .launch(die_launch), .last_die(last_die)
  );

  dd_status_sel #(.STAT_W(STAT_W)) u_stat (
    .clk(clk), .rst_n(rst_n_s), .cmd_valid(cmd_valid), .is_stat_last(is_last),
    .is_stat_d0(is_d0), .is_stat_d1(is_d1), .last_die(last_die),
    .d0_stat(die0_stat), .d1_stat(die1_stat), .stat_out(host_status)
  );

  dd_ready_merge u_rdy (
    .clk(clk), .rst_n(rst_n_s), .die_busy(die_busy), .rdy_n(rdy_n_busy)
  );
endmodule

// File: tb/tb_dual_die_router.sv
module tb_dual_die_router;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [7:0]  cmd_op;
  logic [18:0] cmd_row;
  logic [1:0]  die_busy;
  logic [7:0]  die0_stat, die1_stat;
  logic [1:0]  die_launch;
  logic [7:0]  host_status;
  logic        rdy_n_busy;

  int total = 0;
  int bad = 0;
  bit m_last;     // model: last targeted die
  int m_src;      // 0 none, 1 die0, 2 die1

  always #4 clk = ~clk;

  dual_die_router dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_row(cmd_row), .die_busy(die_busy), .die0_stat(die0_stat),
    .die1_stat(die1_stat), .die_launch(die_launch), .host_status(host_status),
    .rdy_n_busy(rdy_n_busy)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic bit is_status(input logic [7:0] op);
    return op == 8'h70 || op == 8'hF2 || op == 8'hF3;
  endfunction

  function automatic logic [7:0] exp_stat();
    if (m_src == 1) return die0_stat;
    if (m_src == 2) return die1_stat;
    return 8'h00;
  endfunction

  // one cycle: drive at falling edge, check at the next falling edge
  task automatic step(input bit v, input logic [7:0] op, input logic [18:0] row,
                      input logic [1:0] busy, input logic [7:0] s0, input logic [7:0] s1);
    logic [1:0] e_launch;
    string tl, ts;
    bit d;
    cmd_valid = v; cmd_op = op; cmd_row = row; die_busy = busy;
    die0_stat = s0; die1_stat = s1;
    e_launch = 2'b00;
    d = row[18];
    tl = "R10";
    ts = "R8";
    if (v && !is_status(op)) begin
      m_last = d;
      m_src = 0;
      if (!busy[d]) e_launch[d] = 1'b1;
      tl = busy[d] ? "R4" : (d ? "R3" : "R2");
    end else if (v) begin
      if (op == 8'hF2) begin m_src = 1; ts = "R5"; end
      else if (op == 8'hF3) begin m_src = 2; ts = "R6"; end
      else begin m_src = m_last ? 2 : 1; ts = "R7"; end
    end
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(tl, {6'd0, die_launch}, {6'd0, e_launch});
    chk(ts, host_status, exp_stat());
    chk("R9", {7'd0, rdy_n_busy}, {7'd0, ~(|busy)});
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 8'h00; cmd_row = '0;
    die_busy = 2'b00; die0_stat = 8'hE0; die1_stat = 8'hC1;
    m_last = 1'b0; m_src = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {6'd0, die_launch}, 8'h00);
    chk("R1", host_status, 8'h00);
    chk("R1", {7'd0, rdy_n_busy}, 8'h01);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", {6'd0, die_launch}, 8'h00);
    chk("R1", host_status, 8'h00);

    // R7 default die 0 before any operation
    step(1, 8'h70, 19'h0, 2'b00, 8'hE0, 8'hC1);
    // R2 / R3 launches, routing by bit 18
    step(1, 8'h80, 19'h3FFFF, 2'b00, 8'h11, 8'h22);
    step(1, 8'h60, 19'h40000, 2'b00, 8'h11, 8'h22);
    // R7 plain status now points to die 1
    step(1, 8'h70, 19'h0, 2'b00, 8'h33, 8'h44);
    // R8 hold while idle, live byte followed
    step(0, 8'h00, 19'h0, 2'b00, 8'h55, 8'h66);
    step(0, 8'h00, 19'h0, 2'b00, 8'h57, 8'h68);
    // R4 busy die 0 blocked, die 1 still accepts
    step(1, 8'h80, 19'h00010, 2'b01, 8'h80, 8'hE0);
    step(1, 8'h80, 19'h40010, 2'b01, 8'h80, 8'hE0);
    // R7 blocked target still recorded
    step(1, 8'h60, 19'h00020, 2'b01, 8'h81, 8'hE0);
    step(1, 8'h70, 19'h0, 2'b01, 8'h82, 8'hE1);
    // R5 / R6 / R10 die-specific status, no launch
    step(1, 8'hF3, 19'h00000, 2'b10, 8'h90, 8'hA0);
    step(1, 8'hF2, 19'h40000, 2'b11, 8'h91, 8'hA1);
    // R8 non-status command clears selection
    step(1, 8'h00, 19'h40000, 2'b00, 8'h92, 8'hA2);

    for (int i = 0; i < 400; i++) begin
      logic [7:0] op;
      case ($urandom % 6)
        0: op = 8'h70;
        1: op = 8'hF2;
        2: op = 8'hF3;
        3: op = 8'h80;
        4: op = 8'h60;
        default: op = 8'h00;
      endcase
      step(1'($urandom % 3 != 0), op, 19'($urandom), 2'($urandom),
           8'($urandom), 8'($urandom));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule